// File: doc/BRIEF.md
# Dual-Channel Serial Register Front End

This block is the byte-wide host side of a two-channel serial controller. A two-bit address picks the control or data port of one of the two channels. Each channel has sixteen write registers and sixteen read registers. Register 0 is reached directly. Every other register takes two steps: a control write loads a register pointer, and the next control access uses it. The pointer clears itself after each use.

The same decoder performs software resets. A write to pointer 9 can reset one channel or both. Each channel also holds a one-byte receive buffer and a transmit latch. From its stored configuration it derives the line format: parity, stop bits, data bits, and the number of input clocks per serial bit. The bit-level transmitter and receiver sit outside this block. They connect through receive strobes, transmit pulses and the format outputs.

Top module: `dual_serial_regif`

## Requirements
- R1: `bus_addr[0]` selects the port: 0 is control and 1 is data. `bus_addr[1]` selects the channel: 0 is channel B and 1 is channel A. In every per-channel output vector, index 0 (the low slice) belongs to channel B.
- R2: A control write while the pointer is 0 loads the pointer from data bits 2:0. If data bits 5:3 equal 001, 8 is added to the pointer. Any other value in bits 5:3 adds nothing.
- R3: A control write while the pointer is non-zero stores the byte into the pointed write register, and the pointer returns to 0.
- R4: A control read places the pointed read register on `bus_rdata` one cycle after the strobe, and the pointer returns to 0. Read register 0 is status, with bit 0 = character pending, bit 2 = transmit empty and bit 6 = underrun. Read register 1 is 0x07. Read registers 12 and 13 are described in R7. All other read registers return 0. `bus_rdata` holds its value while no read is strobed.
- R5: A control write to pointer 9 resets channels by data bits 7:6: 01 resets B, 10 resets A, 11 resets both, 00 has no effect. The byte is not stored, and the pointer of the writing channel returns to 0.
- R6: A channel reset sets these write registers: 4 = 0x04, 9 = 0xC0, 11 = 0x08, 14 = 0x30, 15 = 0xF8. All other write registers become zero. It also clears the pointer, the receive buffer, the pending flag and the transmit latch. The other channel keeps its state.
- R7: Write registers 12 (time constant low byte) and 13 (time constant high byte) read back unchanged through read registers 12 and 13.
- R8: Write register 4 bit 0 enables parity, and bit 1 selects even parity (0 selects odd). Bits 3:2 = 11 give two stop bits; any other value gives one.
- R9: Write register 5 bits 6:5 set `data_bits` (4 bits per channel) as follows: 00 = 5, 01 = 7, 10 = 6, 11 = 8.
- R10: `bit_clocks` (23 bits per channel) equals (time constant + 2) times a multiplier. Write register 4 bits 7:6 select the multiplier: 00 = 1, 01 = 16, 10 = 32, 11 = 64. All format outputs are registered and follow a register write by one cycle.
- R11: A receive strobe is accepted only when write register 3 bit 0 is set and no character is pending. `rx_ready` shows that condition. A data read returns the buffered byte and clears the pending flag.
- R12: A data write latches `tx_data` for that channel. `tx_strobe` pulses for one cycle only if write register 5 bit 3 is set. Transmit-empty, underrun and all-sent status stay set.
- R13: The synchronous active-high `rst` acts as a reset of both channels and also clears `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 2 | Bit 0 selects control or data, bit 1 selects the channel |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| rx_strobe | input | 2 | Received byte offered, per channel |
| rx_data | input | 16 | Received bytes, per channel |
| rx_ready | output | 2 | Channel can accept a byte |
| tx_strobe | output | 2 | One-cycle transmit pulse, per channel |
| tx_data | output | 16 | Latched transmit bytes |
| par_en | output | 2 | Parity enabled |
| par_even | output | 2 | Even parity selected |
| stop_two | output | 2 | Two stop bits |
| data_bits | output | 8 | Character length, 4 bits per channel |
| bit_clocks | output | 46 | Input clocks per serial bit, 23 bits per channel |

## Verification
Some properties are checked by assertions on every cycle. The pointer returns to zero after any use. A pending receive byte cannot be overwritten. A transmit pulse is always preceded by a data write and reaches at most one channel per cycle. The read byte holds between reads. The format outputs stay within their legal ranges. Other behaviour only the bench scenarios can show: the point-high offset, the reset codes and which channel each one clears, the readback of the time-constant registers, the multiplier products, and the refusal of bytes while receive is disabled or a byte is pending. A behavioural model compares every output on every clock.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int BYTE_W    = 8;
  localparam int NREG      = 16;
  localparam int PTR_W     = $clog2(NREG);
  localparam int NCH       = 2;
  localparam int TC_W      = 2 * BYTE_W;
  localparam int SHIFT_MAX = 6;
  localparam int BCLK_W    = TC_W + 1 + SHIFT_MAX;
  localparam int DBITS_W   = 4;

  localparam logic [2:0]       CMD_PT_HIGH = 3'b001;
  localparam logic [PTR_W-1:0] REG_RXCFG   = PTR_W'(3);
  localparam logic [PTR_W-1:0] REG_FMT     = PTR_W'(4);
  localparam logic [PTR_W-1:0] REG_TXCFG   = PTR_W'(5);
  localparam logic [PTR_W-1:0] REG_RESET   = PTR_W'(9);
  localparam logic [PTR_W-1:0] REG_TC_LO   = PTR_W'(12);
  localparam logic [PTR_W-1:0] REG_TC_HI   = PTR_W'(13);

  localparam logic [BYTE_W-1:0] STAT_IDLE = 8'h44;
  localparam logic [BYTE_W-1:0] SPEC_IDLE = 8'h07;

  function automatic logic [BYTE_W-1:0] wreg_init(input int idx);
    logic [BYTE_W-1:0] v;
    case (idx)
      4:       v = 8'h04;
      9:       v = 8'hC0;
      11:      v = 8'h08;
      14:      v = 8'h30;
      15:      v = 8'hF8;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sio_line_fmt.sv
module sio_line_fmt
  import sio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [BYTE_W-1:0]  fmt_cfg,
  input  logic [BYTE_W-1:0]  data_cfg,
  input  logic [TC_W-1:0]    tconst,
  output logic               par_en,
  output logic               par_even,
  output logic               stop_two,
  output logic [DBITS_W-1:0] data_bits,
  output logic [BCLK_W-1:0]  bit_clocks
);
  logic [TC_W:0]        span;
  logic [BCLK_W-1:0]    span_w;
  logic [BCLK_W-1:0]    clocks_nxt;
  logic [DBITS_W-1:0]   dbits_nxt;

  assign span   = {1'b0, tconst} + (TC_W+1)'(2);
  assign span_w = BCLK_W'(span);

  always_comb begin
    case (fmt_cfg[7:6])
      2'b00:   clocks_nxt = span_w;
      2'b01:   clocks_nxt = span_w << 4;
      2'b10:   clocks_nxt = span_w << 5;
      default: clocks_nxt = span_w << SHIFT_MAX;
    endcase
    case (data_cfg[6:5])
      2'b00:   dbits_nxt = DBITS_W'(5);
      2'b01:   dbits_nxt = DBITS_W'(7);
      2'b10:   dbits_nxt = DBITS_W'(6);
      default: dbits_nxt = DBITS_W'(8);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      par_en     <= 1'b0;
      par_even   <= 1'b0;
      stop_two   <= 1'b0;
      data_bits  <= DBITS_W'(5);
      bit_clocks <= BCLK_W'(2);
    end else begin
      par_en     <= fmt_cfg[0];
      par_even   <= fmt_cfg[1];
      stop_two   <= (fmt_cfg[3:2] == 2'b11);
      data_bits  <= dbits_nxt;
      bit_clocks <= clocks_nxt;
    end
  end

  // R10
  bitclk_floor_chk: assert property (@(posedge clk) disable iff (rst)
    bit_clocks >= BCLK_W'(2));

  // R9
  dbits_range_chk: assert property (@(posedge clk) disable iff (rst)
    (data_bits >= DBITS_W'(5)) && (data_bits <= DBITS_W'(8)));
endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              ctrl_wr,
  input  logic              data_wr,
  input  logic              ctrl_rd,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_strobe,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [PTR_W-1:0]  ptr,
  output logic [BYTE_W-1:0] ctrl_rdata,
  output logic [BYTE_W-1:0] rx_hold,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] fmt_cfg,
  output logic [BYTE_W-1:0] data_cfg,
  output logic [TC_W-1:0]   tconst
);
  logic [BYTE_W-1:0] wr_q [NREG];
  logic              rx_avail;
  logic              reset_now;
  logic              rx_take;

  assign reset_now = rst | soft_rst;
  assign rx_take   = rx_strobe & wr_q[REG_RXCFG][0] & ~rx_avail;
  assign rx_ready  = wr_q[REG_RXCFG][0] & ~rx_avail;
  assign fmt_cfg   = wr_q[REG_FMT];
  assign data_cfg  = wr_q[REG_TXCFG];
  assign tconst    = {wr_q[REG_TC_HI], wr_q[REG_TC_LO]};

  // register pointer: loaded from register 0, self-clearing after use
  always_ff @(posedge clk) begin
    if (reset_now)
      ptr <= '0;
    else if (ctrl_wr)
      ptr <= (ptr == '0) ? {(wdata[5:3] == CMD_PT_HIGH), wdata[2:0]} : '0;
    else if (ctrl_rd)
      ptr <= '0;
  end

  always_ff @(posedge clk) begin
    if (reset_now) begin
      for (int i = 0; i < NREG; i++) wr_q[i] <= wreg_init(i);
    end else if (ctrl_wr && ptr != '0 && ptr != REG_RESET) begin
      wr_q[ptr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (reset_now) begin
      rx_avail <= 1'b0;
      rx_hold  <= '0;
    end else if (rx_take) begin
      rx_avail <= 1'b1;
      rx_hold  <= rx_byte;
    end else if (data_rd) begin
      rx_avail <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (reset_now) begin
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= data_wr & wr_q[REG_TXCFG][3];
      if (data_wr) tx_byte <= wdata;
    end
  end

  always_comb begin
    case (ptr)
      PTR_W'(0): ctrl_rdata = STAT_IDLE | {{(BYTE_W-1){1'b0}}, rx_avail};
      PTR_W'(1): ctrl_rdata = SPEC_IDLE;
      REG_TC_LO: ctrl_rdata = wr_q[REG_TC_LO];
      REG_TC_HI: ctrl_rdata = wr_q[REG_TC_HI];
      default:   ctrl_rdata = '0;
    endcase
  end

  // R3
  ptr_return_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ptr != '0) |=> (ptr == '0));

  // R4
  ptr_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && !ctrl_wr) |=> (ptr == '0));

  // R11
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_avail && !data_rd && !soft_rst) |=> ($stable(rx_hold) && rx_avail));

  // R6
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (ptr == '0 && !rx_avail && !tx_strobe && tx_byte == '0));

  // R12
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |-> $past(data_wr));
endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
  import sio_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [1:0]               bus_addr,
  input  logic [BYTE_W-1:0]        bus_wdata,
  output logic [BYTE_W-1:0]        bus_rdata,
  input  logic [NCH-1:0]           rx_strobe,
  input  logic [NCH*BYTE_W-1:0]    rx_data,
  output logic [NCH-1:0]           rx_ready,
  output logic [NCH-1:0]           tx_strobe,
  output logic [NCH*BYTE_W-1:0]    tx_data,
  output logic [NCH-1:0]           par_en,
  output logic [NCH-1:0]           par_even,
  output logic [NCH-1:0]           stop_two,
  output logic [NCH*DBITS_W-1:0]   data_bits,
  output logic [NCH*BCLK_W-1:0]    bit_clocks
);
  logic              sel_data;
  logic              sel_ch;
  logic [PTR_W-1:0]  ptr_q  [NCH];
  logic [BYTE_W-1:0] crd    [NCH];
  logic [BYTE_W-1:0] hold   [NCH];
  logic [NCH-1:0]    soft_rst;

  assign sel_data = bus_addr[0];
  assign sel_ch   = bus_addr[1];

  // reset codes: bit 6 clears channel B (index 0), bit 7 clears channel A
  always_comb begin
    soft_rst = '0;
    if (bus_wr && !sel_data && ptr_q[sel_ch] == REG_RESET)
      soft_rst = bus_wdata[7:6];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [BYTE_W-1:0] fmt_cfg;
    logic [BYTE_W-1:0] data_cfg;
    logic [TC_W-1:0]   tconst;

    assign hit = (sel_ch == 1'(c));

    sio_chan_regs u_regs (
      .clk        (clk),
      .rst        (rst),
      .soft_rst   (soft_rst[c]),
      .ctrl_wr    (bus_wr & ~sel_data & hit),
      .data_wr    (bus_wr &  sel_data & hit),
      .ctrl_rd    (bus_rd & ~sel_data & hit),
      .data_rd    (bus_rd &  sel_data & hit),
      .wdata      (bus_wdata),
      .rx_strobe  (rx_strobe[c]),
      .rx_byte    (rx_data[c*BYTE_W +: BYTE_W]),
      .ptr        (ptr_q[c]),
      .ctrl_rdata (crd[c]),
      .rx_hold    (hold[c]),
      .rx_ready   (rx_ready[c]),
      .tx_strobe  (tx_strobe[c]),
      .tx_byte    (tx_data[c*BYTE_W +: BYTE_W]),
      .fmt_cfg    (fmt_cfg),
      .data_cfg   (data_cfg),
      .tconst     (tconst)
    );

    sio_line_fmt u_fmt (
      .clk        (clk),
      .rst        (rst),
      .fmt_cfg    (fmt_cfg),
      .data_cfg   (data_cfg),
      .tconst     (tconst),
      .par_en     (par_en[c]),
      .par_even   (par_even[c]),
      .stop_two   (stop_two[c]),
      .data_bits  (data_bits[c*DBITS_W +: DBITS_W]),
      .bit_clocks (bit_clocks[c*BCLK_W +: BCLK_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= sel_data ? hold[sel_ch] : crd[sel_ch];
  end

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R12
  tx_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_strobe));
endmodule

// File: tb/dual_serial_regif_tb.sv
module dual_serial_regif_tb;
  import sio_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  rx_strobe = '0;
  logic [15:0] rx_data = '0;
  logic [1:0]  rx_ready, tx_strobe, par_en, par_even, stop_two;
  logic [15:0] tx_data;
  logic [7:0]  data_bits;
  logic [45:0] bit_clocks;

  dual_serial_regif u_dut (.*);

  int errs = 0, checks = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ptr [2];
  int m_w   [2][16];
  bit m_av  [2];
  int m_hold[2];
  int m_txd [2];
  bit m_txs [2];
  int m_rd;
  int e_pen[2], e_pev[2], e_st2[2], e_db[2], e_bc[2];
  int mch, code;
  bit acc[2];

  function automatic int init_val(int i);
    if (i == 4) return 'h04;
    if (i == 9) return 'hC0;
    if (i == 11) return 'h08;
    if (i == 14) return 'h30;
    if (i == 15) return 'hF8;
    return 0;
  endfunction

  function automatic void chan_reset(int c);
    for (int i = 0; i < 16; i++) m_w[c][i] = init_val(i);
    m_ptr[c] = 0; m_av[c] = 0; m_hold[c] = 0; m_txd[c] = 0; m_txs[c] = 0;
  endfunction

  function automatic int rreg_of(int c, int p);
    if (p == 0) return 'h44 | int'(m_av[c]);
    if (p == 1) return 'h07;
    if (p == 12 || p == 13) return m_w[c][p];
    return 0;
  endfunction

  function automatic void derive(int c);
    int r4, r5, mult, db;
    r4 = m_w[c][4]; r5 = m_w[c][5];
    e_pen[c] = r4 & 1;
    e_pev[c] = (r4 >> 1) & 1;
    e_st2[c] = (((r4 >> 2) & 3) == 3) ? 1 : 0;
    case ((r5 >> 5) & 3)
      0: db = 5; 1: db = 7; 2: db = 6; default: db = 8;
    endcase
    e_db[c] = db;
    case ((r4 >> 6) & 3)
      0: mult = 1; 1: mult = 16; 2: mult = 32; default: mult = 64;
    endcase
    e_bc[c] = ((m_w[c][13] * 256 + m_w[c][12]) + 2) * mult;
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) derive(c);
    for (int c = 0; c < 2; c++) m_txs[c] = 0;
    if (rst) begin
      chan_reset(0); chan_reset(1); m_rd = 0;
    end else begin
      mch = int'(bus_addr[1]);
      for (int c = 0; c < 2; c++)
        acc[c] = rx_strobe[c] && ((m_w[c][3] & 1) == 1) && !m_av[c];
      if (bus_rd) begin
        if (!bus_addr[0]) begin m_rd = rreg_of(mch, m_ptr[mch]); m_ptr[mch] = 0; end
        else begin m_rd = m_hold[mch]; m_av[mch] = 0; end
      end
      for (int c = 0; c < 2; c++)
        if (acc[c]) begin m_hold[c] = int'(rx_data[c*8 +: 8]); m_av[c] = 1; end
      if (bus_wr) begin
        if (bus_addr[0]) begin
          m_txd[mch] = int'(bus_wdata);
          m_txs[mch] = ((m_w[mch][5] >> 3) & 1) == 1;
        end else if (m_ptr[mch] == 0) begin
          m_ptr[mch] = int'(bus_wdata[2:0]) + ((bus_wdata[5:3] == 3'b001) ? 8 : 0);
        end else if (m_ptr[mch] == 9) begin
          code = int'(bus_wdata[7:6]);
          if (code & 1) chan_reset(0);
          if (code & 2) chan_reset(1);
          m_ptr[mch] = 0;
        end else begin
          m_w[mch][m_ptr[mch]] = int'(bus_wdata);
          m_ptr[mch] = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R4 rdata", int'(bus_rdata), m_rd);
      for (int c = 0; c < 2; c++) begin
        chk("R11 rx_ready", int'(rx_ready[c]), int'((m_w[c][3] & 1) == 1 && !m_av[c]));
        chk("R12 tx_strobe", int'(tx_strobe[c]), int'(m_txs[c]));
        chk("R12 tx_data", int'(tx_data[c*8 +: 8]), m_txd[c]);
        chk("R8 par_en", int'(par_en[c]), e_pen[c]);
        chk("R8 par_even", int'(par_even[c]), e_pev[c]);
        chk("R8 stop_two", int'(stop_two[c]), e_st2[c]);
        chk("R9 data_bits", int'(data_bits[c*4 +: 4]), e_db[c]);
        chk("R10 bit_clocks", int'(bit_clocks[c*23 +: 23]), e_bc[c]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  localparam int CH_B = 0, CH_A = 1;

  task automatic op(bit wr, bit rd, int ch, bit dat, int d);
    bus_wr = wr; bus_rd = rd;
    bus_addr = {1'(ch), dat};
    bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wreg(int ch, int r, int v);
    op(1, 0, ch, 0, ((r >= 8) ? 'h08 : 0) | (r & 7));
    op(1, 0, ch, 0, v);
  endtask

  task automatic rreg(int ch, int r, output int v);
    if (r != 0) op(1, 0, ch, 0, ((r >= 8) ? 'h08 : 0) | (r & 7));
    op(0, 1, ch, 0, 0);
    v = int'(bus_rdata);
  endtask

  task automatic rx_pulse(int ch, int b);
    rx_strobe[ch] = 1'b1;
    rx_data[ch*8 +: 8] = 8'(b);
    @(negedge clk);
    rx_strobe = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 / R6: reset state
    rreg(CH_A, 0, v);  chk("R13 status A after reset", v, 'h44);
    rreg(CH_B, 1, v);  chk("R6 read reg 1 B after reset", v, 'h07);
    chk("R13 data_bits B", int'(data_bits[3:0]), 5);
    chk("R13 bit_clocks B", int'(bit_clocks[22:0]), 2);
    chk("R13 rx_ready", int'(rx_ready), 0);

    // R2 / R7 / R1: point-high and time-constant readback
    wreg(CH_B, 12, 'h34);
    wreg(CH_B, 13, 'h01);
    rreg(CH_B, 12, v); chk("R7 B tc low", v, 'h34);
    rreg(CH_B, 13, v); chk("R2 R7 B tc high", v, 'h01);
    rreg(CH_A, 12, v); chk("R1 A tc low untouched", v, 0);

    // R2: other command code adds nothing (pointer 4)
    op(1, 0, CH_B, 0, 'h14);
    op(1, 0, CH_B, 0, 'hC1);
    @(negedge clk);
    chk("R2 parity on via pointer 4", int'(par_en[0]), 1);
    chk("R8 odd parity", int'(par_even[0]), 0);
    chk("R8 one stop", int'(stop_two[0]), 0);
    chk("R10 x64", int'(bit_clocks[22:0]), 'h4D80);

    // R3: pointer returned, next control read hits status
    op(0, 1, CH_B, 0, 0);
    chk("R3 pointer back to 0", int'(bus_rdata), 'h44);

    // R8 / R10: even parity off, two stop, x16
    wreg(CH_B, 4, 'h4E);
    @(negedge clk);
    chk("R8 parity off", int'(par_en[0]), 0);
    chk("R8 even bit", int'(par_even[0]), 1);
    chk("R8 two stop", int'(stop_two[0]), 1);
    chk("R10 x16", int'(bit_clocks[22:0]), 'h1360);

    // R10: max constant, x32 on channel A
    wreg(CH_A, 12, 'hFF);
    wreg(CH_A, 13, 'hFF);
    wreg(CH_A, 4, 'h80);
    @(negedge clk);
    chk("R10 A max x32", int'(bit_clocks[45:23]), 'h200020);

    // R9: character length codes
    wreg(CH_A, 5, 'h20); @(negedge clk);
    chk("R9 code 01 -> 7", int'(data_bits[7:4]), 7);
    wreg(CH_A, 5, 'h40); @(negedge clk);
    chk("R9 code 10 -> 6", int'(data_bits[7:4]), 6);
    wreg(CH_A, 5, 'h60); @(negedge clk);
    chk("R9 code 11 -> 8", int'(data_bits[7:4]), 8);

    // R4: read clears pointer, unmapped reads zero, value holds
    op(1, 0, CH_B, 0, 'h0C);
    op(0, 1, CH_B, 0, 0);  chk("R4 read reg 12", int'(bus_rdata), 'h34);
    op(0, 1, CH_B, 0, 0);  chk("R4 pointer cleared by read", int'(bus_rdata), 'h44);
    rreg(CH_B, 2, v);      chk("R4 unmapped reg", v, 0);
    rreg(CH_B, 13, v);
    repeat (2) @(negedge clk);
    chk("R4 rdata holds", int'(bus_rdata), 'h01);

    // R11: receive acceptance
    rx_pulse(CH_B, 'h5A);
    rreg(CH_B, 0, v);  chk("R11 rx disabled ignored", v, 'h44);
    wreg(CH_B, 3, 'h01);
    chk("R11 ready when enabled", int'(rx_ready[0]), 1);
    rx_pulse(CH_B, 'h5A);
    chk("R11 ready drops when pending", int'(rx_ready[0]), 0);
    rreg(CH_B, 0, v);  chk("R11 pending flag", v, 'h45);
    rx_pulse(CH_B, 'hA5);
    op(0, 1, CH_B, 1, 0);  chk("R11 first byte kept", int'(bus_rdata), 'h5A);
    rreg(CH_B, 0, v);  chk("R11 pending cleared", v, 'h44);
    chk("R11 ready again", int'(rx_ready[0]), 1);

    // R12: transmit latch and gated pulse
    op(1, 0, CH_A, 1, 'h3C);
    chk("R12 no pulse while disabled", int'(tx_strobe[1]), 0);
    chk("R12 byte latched", int'(tx_data[15:8]), 'h3C);
    wreg(CH_A, 5, 'h68);
    op(1, 0, CH_A, 1, 'h99);
    chk("R12 pulse when enabled", int'(tx_strobe[1]), 1);
    chk("R12 new byte", int'(tx_data[15:8]), 'h99);
    @(negedge clk);
    chk("R12 pulse one cycle", int'(tx_strobe[1]), 0);
    rreg(CH_A, 0, v);  chk("R12 status after write", v, 'h44);
    rreg(CH_A, 1, v);  chk("R12 all sent", v, 'h07);

    // R5 / R6: reset codes
    wreg(CH_A, 9, 'h00);
    rreg(CH_A, 12, v); chk("R5 code 00 keeps A", v, 'hFF);
    rreg(CH_B, 12, v); chk("R5 code 00 keeps B", v, 'h34);
    wreg(CH_A, 9, 'h40);
    rreg(CH_B, 12, v); chk("R5 code 01 clears B", v, 0);
    rreg(CH_A, 12, v); chk("R6 A kept on B reset", v, 'hFF);
    chk("R6 B rx disabled after reset", int'(rx_ready[0]), 0);
    wreg(CH_B, 12, 'h34);
    wreg(CH_B, 9, 'h80);
    rreg(CH_A, 12, v); chk("R5 code 10 clears A", v, 0);
    rreg(CH_B, 12, v); chk("R6 B kept on A reset", v, 'h34);
    @(negedge clk);
    chk("R6 A format reset", int'(bit_clocks[45:23]), 2);
    wreg(CH_A, 9, 'hC0);
    rreg(CH_B, 12, v); chk("R5 code 11 clears B", v, 0);
    @(negedge clk);
    chk("R6 B data bits reset", int'(data_bits[3:0]), 5);
    chk("R6 B stop reset", int'(stop_two[0]), 0);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule